// File: doc/BRIEF.md
# Delayed-Write Retire Hazard Guard

This block sits between a command scheduler and the command packet encoder of a DRAM channel shared by several devices. Each device parks the data of its latest write in a buffer and commits it to the array later. The commit is delayed by a number of packet slots, and reads to the same device hold it back further. The guard follows those buffers from the command stream alone and changes the stream where it would damage data. A read that would follow two back-to-back writes to the same device is replaced by a no-op. A precharge of a bank that still has buffered write data is held back.

One clock cycle is one packet slot. Each cycle the scheduler offers one column command and one row command. The guard passes them through, or swaps the column command for a no-op and raises the column stall, or drops the row command and raises the row stall. While a stall is high, the scheduler keeps the same command on its inputs for the next slot. The two pending-write entries store the device and bank of a buffered write and the slots it has aged. They store no row, so a bank reopened on a different row would receive the old data. That is why precharge is blocked.

Top module: `wr_retire_guard`

## Requirements
- R1: Synchronous active-high reset empties both pending-write entries and clears the column history. In the first slot after reset, a read and a precharge both pass.
- R2: Column command encoding is 0 no-op, 1 write, 2 read. Row command encoding is 0 none, 1 activate, 2 precharge. A command that meets no hazard is forwarded unchanged in the same cycle. The device, bank and column fields are always forwarded unchanged.
- R3: A read is offered to device D, and the two column commands issued in the previous two slots were both writes to D. The guard issues a no-op and raises the column stall. In the next slot the held read is issued.
- R4: The write-write-read substitution happens only when both writes and the read target the same device.
- R5: A precharge to a device and bank held by a valid entry is replaced by "none", and the row stall is raised. Precharges to other banks pass, and activates always pass.
- R6: Each slot that is not a same-device read ages an entry by one, up to T_RTR. An entry that has reached T_RTR is released in the next slot that is a no-op or carries a command for another device. With only no-ops after a write in slot t, a precharge of that bank stalls through slot t+T_RTR+1 and passes in slot t+T_RTR+2.
- R7: A read to an entry's device leaves that entry's age unchanged. A string of such reads therefore extends the precharge block by the same number of slots.
- R8: A write to another device releases an entry that has reached T_RTR. An entry younger than T_RTR stays held.
- R9: A write to a device that already has an entry replaces that entry. The old bank is released at once. No two entries ever hold the same device.
- R10: A write to a third device while both entries are busy and unreleased evicts the older entry (entry 0 on equal age) to make room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous reset, active high |
| col_cmd_i | input | 2 | Offered column command |
| col_dev_i | input | DEV_W | Device of the column command |
| col_bank_i | input | BANK_W | Bank of the column command |
| col_addr_i | input | COL_W | Column address |
| row_cmd_i | input | 2 | Offered row command |
| row_dev_i | input | DEV_W | Device of the row command |
| row_bank_i | input | BANK_W | Bank of the row command |
| col_cmd_o | output | 2 | Issued column command |
| col_dev_o | output | DEV_W | Issued column device |
| col_bank_o | output | BANK_W | Issued column bank |
| col_addr_o | output | COL_W | Issued column address |
| row_cmd_o | output | 2 | Issued row command |
| row_dev_o | output | DEV_W | Issued row device |
| row_bank_o | output | BANK_W | Issued row bank |
| col_stall_o | output | 1 | Column command replaced, hold it |
| row_stall_o | output | 1 | Precharge held back, hold it |

## Verification
The bench builds the guard with four devices, eight banks and T_RTR of 3. The short aging window brings the exact slot of release within reach in a few cycles, both after plain no-ops and after a run of five same-device reads. Four devices allow a write to a third device while two entries are still young, so eviction is exercised. They also allow ripe and unripe entries to be released, or kept, by a write to another device.

// File: rtl/wrg_pkg.sv
package wrg_pkg;

    typedef enum logic [1:0] {
        COL_NOP = 2'd0,
        COL_WR  = 2'd1,
        COL_RD  = 2'd2
    } col_op_e;

    typedef enum logic [1:0] {
        ROW_NONE = 2'd0,
        ROW_ACT  = 2'd1,
        ROW_PRER = 2'd2
    } row_op_e;

    localparam int N_ENT = 2;

    function automatic logic is_access(input logic [1:0] op);
        return (op == COL_WR) || (op == COL_RD);
    endfunction

endpackage

// File: rtl/wrg_wwr_detect.sv
module wrg_wwr_detect
    import wrg_pkg::*;
#(
    parameter int DEV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       prop_op,
    input  logic [DEV_W-1:0] prop_dev,
    input  logic [1:0]       iss_op,
    input  logic [DEV_W-1:0] iss_dev,
    output logic             hazard
);

    logic [1:0]       h1_op, h2_op;
    logic [DEV_W-1:0] h1_dev, h2_dev;

    always_ff @(posedge clk) begin
        if (rst) begin
            h1_op  <= COL_NOP;
            h2_op  <= COL_NOP;
            h1_dev <= '0;
            h2_dev <= '0;
        end else begin
            h2_op  <= h1_op;
            h2_dev <= h1_dev;
            h1_op  <= iss_op;
            h1_dev <= iss_dev;
        end
    end

    always_comb begin
        hazard = (prop_op == COL_RD) && (h1_op == COL_WR) && (h2_op == COL_WR)
              && (h1_dev == prop_dev) && (h2_dev == prop_dev);
    end

    // a substituted slot breaks the pattern, so the held read goes next
    p_single_gap_r3: assert property (@(posedge clk) disable iff (rst)
        hazard |=> !hazard);

endmodule

// File: rtl/wrg_tracker.sv
module wrg_tracker
    import wrg_pkg::*;
#(
    parameter int T_RTR  = 4,
    parameter int DEV_W  = 3,
    parameter int BANK_W = 4,
    localparam int AGE_W = $clog2(T_RTR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        iss_op,
    input  logic [DEV_W-1:0]  iss_dev,
    input  logic [BANK_W-1:0] iss_bank,
    input  logic [DEV_W-1:0]  q_dev,
    input  logic [BANK_W-1:0] q_bank,
    output logic              hit
);

    typedef struct packed {
        logic              v;
        logic [DEV_W-1:0]  dev;
        logic [BANK_W-1:0] bank;
        logic [AGE_W-1:0]  age;
    } ent_t;

    localparam logic [AGE_W-1:0] RIPE = AGE_W'(T_RTR);

    ent_t ent_q [N_ENT];
    ent_t ent_d [N_ENT];
    logic same  [N_ENT];
    logic keep  [N_ENT];
    logic tgt;
    logic has_rep;
    logic wr;

    always_comb begin
        wr      = (iss_op == COL_WR);
        hit     = 1'b0;
        has_rep = 1'b0;
        tgt     = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            same[i] = ent_q[i].v && (ent_q[i].dev == iss_dev) && is_access(iss_op);
            keep[i] = ent_q[i].v && !(ent_q[i].age == RIPE && !same[i])
                   && !(same[i] && wr);
            ent_d[i]   = ent_q[i];
            ent_d[i].v = keep[i];
            if (!(same[i] && iss_op == COL_RD) && ent_q[i].age < RIPE)
                ent_d[i].age = ent_q[i].age + 1'b1;
            if (ent_q[i].v && ent_q[i].dev == q_dev && ent_q[i].bank == q_bank)
                hit = 1'b1;
            if (same[i] && wr) begin
                has_rep = 1'b1;
                tgt     = 1'(i);
            end
        end
        if (!has_rep) begin
            if (!keep[0])      tgt = 1'b0;
            else if (!keep[1]) tgt = 1'b1;
            else               tgt = (ent_q[0].age >= ent_q[1].age) ? 1'b0 : 1'b1;
        end
        if (wr) begin
            ent_d[tgt].v    = 1'b1;
            ent_d[tgt].dev  = iss_dev;
            ent_d[tgt].bank = iss_bank;
            ent_d[tgt].age  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= ent_d[i];
        end
    end

    p_unique_dev_r9: assert property (@(posedge clk) disable iff (rst)
        (ent_q[0].v && ent_q[1].v) |-> (ent_q[0].dev != ent_q[1].dev));

    for (genvar g = 0; g < N_ENT; g++) begin : g_chk
        p_age_cap_r6: assert property (@(posedge clk) disable iff (rst)
            ent_q[g].age <= RIPE);
        p_hold_off_r7: assert property (@(posedge clk) disable iff (rst)
            (ent_q[g].v && iss_op == COL_RD && iss_dev == ent_q[g].dev)
            |=> (ent_q[g].v && $stable(ent_q[g].age)));
    end

endmodule

// File: rtl/wr_retire_guard.sv
module wr_retire_guard
    import wrg_pkg::*;
#(
    parameter int NUM_DEV  = 8,
    parameter int NUM_BANK = 16,
    parameter int COL_W    = 7,
    parameter int T_RTR    = 4,
    localparam int DEV_W   = $clog2(NUM_DEV),
    localparam int BANK_W  = $clog2(NUM_BANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        col_cmd_i,
    input  logic [DEV_W-1:0]  col_dev_i,
    input  logic [BANK_W-1:0] col_bank_i,
    input  logic [COL_W-1:0]  col_addr_i,
    input  logic [1:0]        row_cmd_i,
    input  logic [DEV_W-1:0]  row_dev_i,
    input  logic [BANK_W-1:0] row_bank_i,
    output logic [1:0]        col_cmd_o,
    output logic [DEV_W-1:0]  col_dev_o,
    output logic [BANK_W-1:0] col_bank_o,
    output logic [COL_W-1:0]  col_addr_o,
    output logic [1:0]        row_cmd_o,
    output logic [DEV_W-1:0]  row_dev_o,
    output logic [BANK_W-1:0] row_bank_o,
    output logic              col_stall_o,
    output logic              row_stall_o
);

    logic wwr_hazard;
    logic bank_held;

    wrg_wwr_detect #(.DEV_W(DEV_W)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .prop_op  (col_cmd_i),
        .prop_dev (col_dev_i),
        .iss_op   (col_cmd_o),
        .iss_dev  (col_dev_o),
        .hazard   (wwr_hazard)
    );

    wrg_tracker #(.T_RTR(T_RTR), .DEV_W(DEV_W), .BANK_W(BANK_W)) u_tracker (
        .clk      (clk),
        .rst      (rst),
        .iss_op   (col_cmd_o),
        .iss_dev  (col_dev_o),
        .iss_bank (col_bank_o),
        .q_dev    (row_dev_i),
        .q_bank   (row_bank_i),
        .hit      (bank_held)
    );

    always_comb begin
        col_dev_o   = col_dev_i;
        col_bank_o  = col_bank_i;
        col_addr_o  = col_addr_i;
        col_stall_o = wwr_hazard;
        col_cmd_o   = wwr_hazard ? 2'(COL_NOP) : col_cmd_i;
        row_dev_o   = row_dev_i;
        row_bank_o  = row_bank_i;
        row_stall_o = bank_held && (row_cmd_i == ROW_PRER);
        row_cmd_o   = row_stall_o ? 2'(ROW_NONE) : row_cmd_i;
    end

    p_col_sub_r3: assert property (@(posedge clk) disable iff (rst)
        col_stall_o |-> (col_cmd_i == COL_RD && col_cmd_o == COL_NOP));
    p_stall_only_prer_r5: assert property (@(posedge clk) disable iff (rst)
        row_stall_o |-> (row_cmd_i == ROW_PRER));
    p_act_free_r5: assert property (@(posedge clk) disable iff (rst)
        (row_cmd_i == ROW_ACT) |-> (row_cmd_o == ROW_ACT && !row_stall_o));
    p_fields_r2: assert property (@(posedge clk) disable iff (rst)
        (col_dev_o == col_dev_i) && (row_bank_o == row_bank_i));

endmodule

// File: tb/wr_retire_guard_test.sv
`timescale 1ns/1ps
module wr_retire_guard_test;

    localparam logic [1:0] NOP = 2'd0, WR = 2'd1, RD = 2'd2;
    localparam logic [1:0] NONE = 2'd0, ACT = 2'd1, PRE = 2'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] col_cmd_i = NOP, row_cmd_i = NONE;
    logic [1:0] col_dev_i = '0, row_dev_i = '0;
    logic [2:0] col_bank_i = '0, row_bank_i = '0;
    logic [5:0] col_addr_i = '0;
    logic [1:0] col_cmd_o, row_cmd_o, col_dev_o, row_dev_o;
    logic [2:0] col_bank_o, row_bank_o;
    logic [5:0] col_addr_o;
    logic col_stall_o, row_stall_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] c;
        logic [1:0] cd;
        logic [1:0] r;
        logic       cs;
        logic       rs;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    wr_retire_guard #(.NUM_DEV(4), .NUM_BANK(8), .COL_W(6), .T_RTR(3)) uut (
        .clk(clk), .rst(rst),
        .col_cmd_i(col_cmd_i), .col_dev_i(col_dev_i), .col_bank_i(col_bank_i),
        .col_addr_i(col_addr_i), .row_cmd_i(row_cmd_i), .row_dev_i(row_dev_i),
        .row_bank_i(row_bank_i), .col_cmd_o(col_cmd_o), .col_dev_o(col_dev_o),
        .col_bank_o(col_bank_o), .col_addr_o(col_addr_o), .row_cmd_o(row_cmd_o),
        .row_dev_o(row_dev_o), .row_bank_o(row_bank_o),
        .col_stall_o(col_stall_o), .row_stall_o(row_stall_o)
    );

    task automatic step(input logic [1:0] c, input logic [1:0] cd, input logic [2:0] cb,
                        input logic [5:0] ca, input logic [1:0] r, input logic [1:0] rd,
                        input logic [2:0] rb, input logic [1:0] ec, input logic [1:0] er,
                        input logic ecs, input logic ers, input string tag);
        exp_t e;
        @(negedge clk);
        col_cmd_i = c; col_dev_i = cd; col_bank_i = cb; col_addr_i = ca;
        row_cmd_i = r; row_dev_i = rd; row_bank_i = rb;
        e.c = ec; e.cd = cd; e.r = er; e.cs = ecs; e.rs = ers; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(NOP, 0, 0, 0, NONE, 0, 0, NOP, NONE, 0, 0, "R2");
    endtask

    // monitor: compares issued outputs mid-slot, away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (col_cmd_o !== e.c || col_dev_o !== e.cd || row_cmd_o !== e.r ||
                    col_stall_o !== e.cs || row_stall_o !== e.rs) begin
                    fails++;
                    $display("FAIL %s: col=%0d dev=%0d row=%0d cs=%0b rs=%0b expected col=%0d dev=%0d row=%0d cs=%0b rs=%0b",
                             e.tag, col_cmd_o, col_dev_o, row_cmd_o, col_stall_o, row_stall_o,
                             e.c, e.cd, e.r, e.cs, e.rs);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: clean state right after reset
        step(RD, 0, 0, 0, PRE, 0, 0, RD, PRE, 0, 0, "R1");
        idle(5);

        // R5 / R6: block and release after plain no-ops (T_RTR = 3)
        step(WR,  0, 1, 7, NONE, 0, 0, WR,  NONE, 0, 0, "R2");
        step(NOP, 0, 0, 0, PRE,  0, 1, NOP, NONE, 0, 1, "R5");
        step(NOP, 0, 0, 0, PRE,  0, 2, NOP, PRE,  0, 0, "R5");
        step(NOP, 0, 0, 0, ACT,  0, 1, NOP, ACT,  0, 0, "R5");
        step(NOP, 0, 0, 0, PRE,  0, 1, NOP, NONE, 0, 1, "R6");
        step(NOP, 0, 0, 0, PRE,  0, 1, NOP, PRE,  0, 0, "R6");
        idle(2);

        // R7: same-device reads hold the entry
        step(WR, 1, 3, 0, NONE, 0, 0, WR, NONE, 0, 0, "R7");
        for (int i = 0; i < 5; i++)
            step(RD, 1, 0, 6'(i), PRE, 1, 3, RD, NONE, 0, 1, "R7");
        for (int i = 0; i < 4; i++)
            step(NOP, 0, 0, 0, PRE, 1, 3, NOP, NONE, 0, 1, "R7");
        step(NOP, 0, 0, 0, PRE, 1, 3, NOP, PRE, 0, 0, "R7");
        idle(2);

        // R3: write-write-read to one device
        step(WR, 2, 0, 1, NONE, 0, 0, WR,  NONE, 0, 0, "R3");
        step(WR, 2, 1, 2, NONE, 0, 0, WR,  NONE, 0, 0, "R3");
        step(RD, 2, 4, 5, NONE, 0, 0, NOP, NONE, 1, 0, "R3");
        step(RD, 2, 4, 5, NONE, 0, 0, RD,  NONE, 0, 0, "R3");
        idle(5);

        // R4: pattern across devices is not a hazard
        step(WR, 2, 0, 1, NONE, 0, 0, WR, NONE, 0, 0, "R4");
        step(WR, 3, 0, 1, NONE, 0, 0, WR, NONE, 0, 0, "R4");
        step(RD, 2, 0, 1, NONE, 0, 0, RD, NONE, 0, 0, "R4");
        idle(5);
        step(WR, 2, 0, 1, NONE, 0, 0, WR, NONE, 0, 0, "R4");
        step(WR, 2, 1, 1, NONE, 0, 0, WR, NONE, 0, 0, "R4");
        step(RD, 3, 0, 1, NONE, 0, 0, RD, NONE, 0, 0, "R4");
        idle(5);

        // R8 / R10: young entry survives, third device evicts the older
        step(WR,  0, 5, 0, NONE, 0, 0, WR,  NONE, 0, 0, "R8");
        step(WR,  1, 0, 0, NONE, 0, 0, WR,  NONE, 0, 0, "R8");
        step(NOP, 0, 0, 0, PRE,  0, 5, NOP, NONE, 0, 1, "R8");
        step(WR,  2, 6, 0, NONE, 0, 0, WR,  NONE, 0, 0, "R10");
        step(NOP, 0, 0, 0, PRE,  0, 5, NOP, PRE,  0, 0, "R10");
        step(NOP, 0, 0, 0, PRE,  1, 0, NOP, NONE, 0, 1, "R10");
        idle(6);

        // R8: ripe entry released by a write to another device
        step(WR, 3, 2, 0, NONE, 0, 0, WR, NONE, 0, 0, "R8");
        for (int i = 0; i < 3; i++)
            step(RD, 0, 0, 6'(i), NONE, 0, 0, RD, NONE, 0, 0, "R8");
        step(WR,  0, 1, 0, PRE, 3, 2, WR,  NONE, 0, 1, "R8");
        step(NOP, 0, 0, 0, PRE, 3, 2, NOP, PRE,  0, 0, "R8");
        idle(6);

        // R9: same-device write replaces the entry
        step(WR,  1, 4, 0, NONE, 0, 0, WR,  NONE, 0, 0, "R9");
        step(WR,  1, 7, 0, NONE, 0, 0, WR,  NONE, 0, 0, "R9");
        step(NOP, 0, 0, 0, PRE,  1, 4, NOP, PRE,  0, 0, "R9");
        step(NOP, 0, 0, 0, PRE,  1, 7, NOP, NONE, 0, 1, "R9");
        idle(6);

        @(negedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule